// File: doc/BRIEF.md
# I2C Packet Master Sequencer

This block is the master side of an I2C bus. One write to its command word is enough to run a whole packet. Software picks a 7-bit target and any mix of five phase flags: open, transmit one byte, receive one byte, mark the received byte as final, and close. The engine then runs the open condition, the address byte with its read/write bit, the data byte with its acknowledge slot, and the close condition. It drives both bus lines through this sequence with no software step between phases. When the packet ends, a single completion flag is raised. A packet that does not close keeps the bus, so the next command can continue the transfer or issue a repeated open condition.

The block has a four-word register port. Word 0 holds the command. Word 1 is the byte buffer, which also shows bus ownership. Word 2 holds the interrupt status, whose bits are cleared by writing 1. Word 3 holds the interrupt enables. The lines are open drain: each output asks for its line to be pulled low, and the true SDA level comes back on `sdaIn`. Every bit slot lasts four quarters of `QUARTER_CYCLES` clocks each. SCL is low in the first and last quarter, and SDA is sampled at the end of the second quarter.

Top module: `i2c_pkt_master`

## Requirements
- R1: After reset all four register words read 0, neither line is pulled low and `irq` is low.
- R2: The command word (word 0) holds the target in bits 30:24, a go bit at 16, and the phase flags open=0, transmit=1, receive=3, final=4, close=5. A command write with bit 16 clear starts nothing.
- R3: An open condition pulls SDA low while SCL is high. On an idle bus SCL stays high beforehand. When the bus is already owned the condition is a repeated open. Ownership (word 1 bit 16) is set after it.
- R4: The address byte is the 7 target bits, MSB first, followed by a read/write bit that is 1 exactly when the receive flag is set. SDA changes only while SCL is low.
- R5: Transmit sends word 1 bits 7:0, MSB first. A slave ACK after the address or data byte sets status bit 0, and a NAK sets bit 1. A NAKed address skips the data phase. Transmit wins when both data flags are set.
- R6: Receive shifts in 8 bits, which are readable at word 1 bits 15:8. The master answers with ACK (SDA low) unless the final flag is set, in which case it leaves SDA high.
- R7: A close condition releases SDA while SCL is high. Afterwards both lines are released and ownership is cleared.
- R8: A packet without close leaves SCL pulled low and ownership set. A following receive command without open continues the byte stream.
- R9: Status bit 16 (done) sets once every requested phase has finished. This includes an address-only packet and a go write with no phase flags.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: `irq` is high exactly when some status bit is set whose enable bit (word 3, same position) is set.
- R12: A command write while a packet is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 2 | Register word select |
| regWe | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of selected word |
| irq | output | 1 | Interrupt request |
| sdaIn | input | 1 | Sensed SDA level |
| sclDriveLow | output | 1 | Pull SCL low |
| sdaDriveLow | output | 1 | Pull SDA low |

## Verification
The bench builds the block with `QUARTER_CYCLES` = 3, so a bit slot is 12 clocks. At that length a full packet takes a few hundred clocks, and forty random packets fit easily alongside the directed ones: NAKed address and data, repeated open on an owned bus, a receive stream carried across two commands, and a command written mid-packet. The divider has only two bits at that value, which exercises its wrap on every quarter. The same quarter arithmetic applies unchanged at the default of 25.

// File: rtl/i2cpm_pkg.sv
package i2cpm_pkg;

  typedef enum logic [2:0] {
    SLOT_IDLE, SLOT_START, SLOT_SEND, SLOT_RECV, SLOT_STOP
  } slot_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_ADDR, PH_TX, PH_RX, PH_STOP
  } phase_e;

  // strobes from the sequencer to the bit path
  typedef struct packed {
    slot_e      slot;
    logic       busOwned;
    logic       load;
    logic [7:0] loadVal;
    logic       driveAck;
    logic       ackBit;
  } ctrl2dp_t;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_BUF  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_IEN  = 2'd3;

  localparam int CMD_OPEN  = 0;
  localparam int CMD_TX    = 1;
  localparam int CMD_RX    = 3;
  localparam int CMD_FINAL = 4;
  localparam int CMD_CLOSE = 5;
  localparam int CMD_GO    = 16;
  localparam int CMD_TGT   = 24;

  localparam int STAT_ACK  = 0;
  localparam int STAT_NAK  = 1;
  localparam int STAT_DONE = 16;
  localparam int BUF_OWNED = 16;

endpackage

// File: rtl/i2cpm_bitpath.sv
module i2cpm_bitpath
  import i2cpm_pkg::*;
#(
  parameter int QUARTER_CYCLES = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrl2dp_t   ctl,
  input  logic       sdaIn,
  output logic       slotDone,
  output logic       sampleBit,
  output logic [7:0] rxShift,
  output logic       sclDriveLow,
  output logic       sdaDriveLow
);

  localparam int CNT_W = $clog2(QUARTER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUARTER_CYCLES - 1);

  logic [CNT_W-1:0] divCnt;
  logic [1:0]       qtr;
  logic [7:0]       txShift;
  logic             tick, sendBit, sclLowNext, sdaLowNext, sclHighData;

  assign tick     = (divCnt == CNT_LAST);
  assign slotDone = (ctl.slot != SLOT_IDLE) && tick && (qtr == 2'd3);
  assign sendBit  = ctl.driveAck ? ctl.ackBit : txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      qtr    <= '0;
    end else if (ctl.slot == SLOT_IDLE) begin
      divCnt <= '0;
      qtr    <= '0;
    end else if (tick) begin
      divCnt <= '0;
      qtr    <= qtr + 2'd1;
    end else begin
      divCnt <= divCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (ctl.load) begin
      txShift <= ctl.loadVal;
    end else if (slotDone && ctl.slot == SLOT_SEND && !ctl.driveAck) begin
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleBit <= 1'b1;
      rxShift   <= '0;
    end else if (ctl.slot == SLOT_RECV && tick && qtr == 2'd1) begin
      sampleBit <= sdaIn;
      rxShift   <= {rxShift[6:0], sdaIn};
    end
  end

  always_comb begin
    sclLowNext = 1'b0;
    sdaLowNext = 1'b0;
    unique case (ctl.slot)
      SLOT_IDLE:  sclLowNext = ctl.busOwned;
      SLOT_START: begin
        sclLowNext = (qtr == 2'd0 && ctl.busOwned) || qtr == 2'd3;
        sdaLowNext = qtr[1];
      end
      SLOT_SEND: begin
        sclLowNext = (qtr == 2'd0) || (qtr == 2'd3);
        sdaLowNext = !sendBit;
      end
      SLOT_RECV:  sclLowNext = (qtr == 2'd0) || (qtr == 2'd3);
      SLOT_STOP: begin
        sclLowNext = (qtr == 2'd0);
        sdaLowNext = !qtr[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclDriveLow <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else begin
      sclDriveLow <= sclLowNext;
      sdaDriveLow <= sdaLowNext;
    end
  end

  assign sclHighData = (ctl.slot == SLOT_SEND || ctl.slot == SLOT_RECV) &&
                       (qtr == 2'd1 || qtr == 2'd2);

  AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sclHighData && $past(sclHighData)) |-> $stable(sdaLowNext)); // R4

  AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.slot == SLOT_IDLE && !ctl.busOwned) |=> (!sclDriveLow && !sdaDriveLow)); // R7

endmodule

// File: rtl/i2cpm_ctrl.sv
module i2cpm_ctrl
  import i2cpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irq,
  input  logic        slotDone,
  input  logic        sampleBit,
  input  logic [7:0]  rxShift,
  output ctrl2dp_t    ctl
);

  phase_e     state, nState;
  logic [3:0] bitIdx;
  logic [6:0] cTgt;
  logic       cOpen, cTx, cRx, cFinal, cClose;
  logic [7:0] txBuf, rxData;
  logic       busOwned;
  logic [2:0] statBits, ienBits, statSet, statClr;
  logic       cmdWrite, cmdAccept, noPhase, ackSlotEnd, pktFinish;
  phase_e     afterData;
  logic       unusedBits;

  assign unusedBits = ^{regWdata[31], regWdata[23:17], regWdata[15:8]};

  assign cmdWrite   = regWe && regAddr == REG_CMD;
  assign cmdAccept  = cmdWrite && regWdata[CMD_GO] && state == PH_IDLE;
  assign noPhase    = !(regWdata[CMD_OPEN] | regWdata[CMD_TX] |
                        regWdata[CMD_RX] | regWdata[CMD_CLOSE]);
  assign ackSlotEnd = slotDone && bitIdx == 4'd8;
  assign afterData  = cClose ? PH_STOP : PH_IDLE;

  always_comb begin
    nState = state;
    unique case (state)
      PH_IDLE: if (cmdAccept) begin
        if (regWdata[CMD_OPEN])       nState = PH_START;
        else if (regWdata[CMD_TX])    nState = PH_TX;
        else if (regWdata[CMD_RX])    nState = PH_RX;
        else if (regWdata[CMD_CLOSE]) nState = PH_STOP;
      end
      PH_START: if (slotDone) nState = PH_ADDR;
      PH_ADDR: if (ackSlotEnd) begin
        if (sampleBit)  nState = afterData;
        else if (cTx)   nState = PH_TX;
        else if (cRx)   nState = PH_RX;
        else            nState = afterData;
      end
      PH_TX, PH_RX: if (ackSlotEnd) nState = afterData;
      PH_STOP: if (slotDone) nState = PH_IDLE;
      default: nState = PH_IDLE;
    endcase
  end

  assign pktFinish = (state != PH_IDLE && nState == PH_IDLE) || (cmdAccept && noPhase);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= PH_IDLE;
      bitIdx <= '0;
    end else begin
      state <= nState;
      if (nState != state) bitIdx <= '0;
      else if (slotDone)   bitIdx <= bitIdx + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cTgt <= '0; cOpen <= 1'b0; cTx <= 1'b0; cRx <= 1'b0;
      cFinal <= 1'b0; cClose <= 1'b0;
    end else if (cmdAccept) begin
      cTgt   <= regWdata[CMD_TGT +: 7];
      cOpen  <= regWdata[CMD_OPEN];
      cTx    <= regWdata[CMD_TX];
      cRx    <= regWdata[CMD_RX];
      cFinal <= regWdata[CMD_FINAL];
      cClose <= regWdata[CMD_CLOSE];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOwned <= 1'b0;
      txBuf    <= '0;
      rxData   <= '0;
    end else begin
      if (state == PH_START && slotDone)      busOwned <= 1'b1;
      else if (state == PH_STOP && slotDone)  busOwned <= 1'b0;
      if (regWe && regAddr == REG_BUF)        txBuf <= regWdata[7:0];
      if (state == PH_RX && slotDone && bitIdx == 4'd7) rxData <= rxShift;
    end
  end

  // status: set wins over a same-cycle clear
  assign statSet[0] = ackSlotEnd && (state == PH_ADDR || state == PH_TX) && !sampleBit;
  assign statSet[1] = ackSlotEnd && (state == PH_ADDR || state == PH_TX) && sampleBit;
  assign statSet[2] = pktFinish;
  assign statClr = (regWe && regAddr == REG_STAT) ?
                   {regWdata[STAT_DONE], regWdata[STAT_NAK], regWdata[STAT_ACK]} : 3'b000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statBits <= '0;
      ienBits  <= '0;
    end else begin
      statBits <= (statBits & ~statClr) | statSet;
      if (regWe && regAddr == REG_IEN)
        ienBits <= {regWdata[STAT_DONE], regWdata[STAT_NAK], regWdata[STAT_ACK]};
    end
  end

  assign irq = |(statBits & ienBits);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      REG_CMD: begin
        regRdata[CMD_TGT +: 7] = cTgt;
        regRdata[CMD_GO]       = (state != PH_IDLE);
        regRdata[CMD_OPEN]     = cOpen;
        regRdata[CMD_TX]       = cTx;
        regRdata[CMD_RX]       = cRx;
        regRdata[CMD_FINAL]    = cFinal;
        regRdata[CMD_CLOSE]    = cClose;
      end
      REG_BUF: regRdata = {15'd0, busOwned, rxData, txBuf};
      REG_STAT: begin
        regRdata[STAT_ACK]  = statBits[0];
        regRdata[STAT_NAK]  = statBits[1];
        regRdata[STAT_DONE] = statBits[2];
      end
      default: begin
        regRdata[STAT_ACK]  = ienBits[0];
        regRdata[STAT_NAK]  = ienBits[1];
        regRdata[STAT_DONE] = ienBits[2];
      end
    endcase
  end

  always_comb begin
    ctl.busOwned = busOwned;
    ctl.ackBit   = cFinal;
    ctl.driveAck = (state == PH_RX) && bitIdx == 4'd8;
    ctl.load     = (nState != state) && (nState == PH_ADDR || nState == PH_TX);
    ctl.loadVal  = (nState == PH_ADDR) ? {cTgt, cRx} : txBuf;
    unique case (state)
      PH_START:     ctl.slot = SLOT_START;
      PH_STOP:      ctl.slot = SLOT_STOP;
      PH_ADDR, PH_TX: ctl.slot = (bitIdx < 4'd8) ? SLOT_SEND : SLOT_RECV;
      PH_RX:        ctl.slot = (bitIdx < 4'd8) ? SLOT_RECV : SLOT_SEND;
      default:      ctl.slot = SLOT_IDLE;
    endcase
  end

  AST_CMD_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (state != PH_IDLE && cmdWrite) |=> $stable(cTgt)); // R12

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statBits[2]) |-> (state == PH_IDLE)); // R9

  AST_ACK_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statBits[0]) |-> $past(state == PH_ADDR || state == PH_TX)); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ienBits != 3'b000)); // R11

  AST_OWN_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOwned) |-> $past(state == PH_START)); // R3

endmodule

// File: rtl/i2c_pkt_master.sv
module i2c_pkt_master
  import i2cpm_pkg::*;
#(
  parameter int QUARTER_CYCLES = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irq,
  input  logic        sdaIn,
  output logic        sclDriveLow,
  output logic        sdaDriveLow
);

  ctrl2dp_t   ctl;
  logic       slotDone, sampleBit;
  logic [7:0] rxShift;

  i2cpm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .slotDone(slotDone), .sampleBit(sampleBit), .rxShift(rxShift), .ctl(ctl)
  );

  i2cpm_bitpath #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_bitpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaIn(sdaIn),
    .slotDone(slotDone), .sampleBit(sampleBit), .rxShift(rxShift),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: tb/tb_i2c_pkt_master.sv
module tb_i2c_pkt_master;

  localparam int CLK_PERIOD = 10;
  localparam int QUARTER    = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq, sdaIn, sclDriveLow, sdaDriveLow;
  logic        slvLow = 1'b0;

  int nChecks = 0;
  int nFail   = 0;

  assign sdaIn = !(sdaDriveLow || slvLow);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_pkt_master #(.QUARTER_CYCLES(QUARTER)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  // ---------------- slave model ----------------
  logic       sclPrev = 1'b1, sdaPrev = 1'b1;
  int         rises = 0, byteCnt = 0, rdIdx = 0, startCnt = 0, stopCnt = 0;
  logic       isRead = 1'b0, addrAcked = 1'b0, masterAck = 1'b0;
  logic [7:0] shiftIn = '0, capAddr = '0, capData = '0, rxBase = '0;
  logic       ackAddrCfg = 1'b1, ackDataCfg = 1'b1;

  function automatic logic [7:0] slvByte(input logic [7:0] base, input int idx);
    return base + 8'(idx * 8'h37);
  endfunction

  always @(negedge clk) begin
    logic sclB, sdaB;
    logic [7:0] cur;
    sclB = !sclDriveLow;
    sdaB = sdaIn;
    cur  = slvByte(rxBase, rdIdx);
    if (sclB && sclPrev && sdaPrev && !sdaB) begin
      startCnt++; rises = 0; byteCnt = 0; isRead = 1'b0; rdIdx = 0; slvLow = 1'b0;
    end else if (sclB && sclPrev && !sdaPrev && sdaB) begin
      stopCnt++; rises = 0; slvLow = 1'b0;
    end else if (sclB && !sclPrev) begin
      rises++;
      if (rises <= 8 && !(isRead && byteCnt > 0)) shiftIn = {shiftIn[6:0], sdaB};
      if (rises == 9 && isRead && byteCnt > 0) masterAck = sdaB;
    end else if (!sclB && sclPrev) begin
      if (rises == 8) begin
        if (isRead && byteCnt > 0) slvLow = 1'b0;
        else if (byteCnt == 0) begin capAddr = shiftIn; slvLow = ackAddrCfg; end
        else begin capData = shiftIn; slvLow = ackDataCfg; end
      end else if (rises == 9) begin
        slvLow = 1'b0; rises = 0;
        if (byteCnt == 0) begin
          isRead = capAddr[0]; addrAcked = ackAddrCfg; byteCnt = 1;
          if (isRead && ackAddrCfg) begin cur = slvByte(rxBase, rdIdx); slvLow = !cur[7]; end
        end else begin
          byteCnt++;
          if (isRead && !masterAck) begin
            rdIdx++; cur = slvByte(rxBase, rdIdx); slvLow = !cur[7];
          end
        end
      end else if (rises >= 1 && rises <= 7 && isRead && byteCnt > 0 && addrAcked) begin
        slvLow = !cur[7 - rises];
      end
    end
    sclPrev = sclB;
    sdaPrev = sdaB;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  function automatic logic [31:0] mkCmd(input bit s, t, r, l, p, input logic [6:0] a);
    return {1'b0, a, 7'd0, 1'b1, 10'd0, p, l, r, 1'b0, t, s};
  endfunction

  task automatic runPacket(input bit s, t, r, l, p, input logic [6:0] a, input logic [7:0] d,
                           input bit aAck, dAck, input logic [7:0] rb, input int rdI, input bit intr);
    logic [31:0] v, bufV;
    int st0, sp0, guard;
    bit addrOk, txDone, rxDone, expAck, expNak, busyBefore, expBusy;
    ackAddrCfg = aAck; ackDataCfg = dAck; rxBase = rb;
    rd(1, bufV); busyBefore = bufV[16];
    wr(1, {24'd0, d});
    wr(2, 32'hFFFF_FFFF);
    st0 = startCnt; sp0 = stopCnt;
    wr(0, mkCmd(s, t, r, l, p, a));
    if (intr) begin
      repeat (20) @(negedge clk);
      wr(0, mkCmd(1, 0, 0, 0, 1, a ^ 7'h7F));
    end
    guard = 0;
    do begin rd(2, v); guard++; end while (!v[16] && guard < 20000);
    chk(v[16], "R9 done flag", v, 32'h1_0000);
    repeat (3) @(negedge clk);
    addrOk = !s || aAck;
    txDone = t && addrOk;
    rxDone = !t && r && addrOk;
    expAck = (s && aAck) || (txDone && dAck);
    expNak = (s && !aAck) || (txDone && !dAck);
    expBusy = p ? 1'b0 : (s ? 1'b1 : busyBefore);
    rd(2, v);
    chk(v == {15'd0, 1'b1, 14'd0, expNak, expAck}, "R5 status ack/nak", v,
        {15'd0, 1'b1, 14'd0, expNak, expAck});
    chk(startCnt - st0 == int'(s), "R3 open count", startCnt - st0, s);
    chk(stopCnt - sp0 == int'(p), "R7 close count", stopCnt - sp0, p);
    if (s) chk(capAddr == {a, r}, "R4 address byte", capAddr, {a, r});
    if (txDone) chk(capData == d, "R5 data byte", capData, d);
    rd(1, bufV);
    if (rxDone) begin
      chk(bufV[15:8] == slvByte(rb, rdI), "R6 received byte", bufV[15:8], slvByte(rb, rdI));
      chk(masterAck == l, "R6 master ack/nak", masterAck, l);
    end
    chk(bufV[16] == expBusy, "R8 ownership bit", bufV[16], expBusy);
    chk(sclDriveLow == expBusy, "R8 SCL hold", sclDriveLow, expBusy);
    if (p) chk(sdaDriveLow == 1'b0, "R7 SDA released", sdaDriveLow, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] v;
    int st0, seedDummy;
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk(v == 32'd0, "R1 reset register", v, 0);
    end
    chk(!sclDriveLow && !sdaDriveLow && !irq, "R1 reset lines", {sclDriveLow, sdaDriveLow, irq}, 0);

    // R2 write without go bit starts nothing
    st0 = startCnt;
    wr(0, mkCmd(1, 1, 0, 0, 1, 7'h22) & ~32'h1_0000);
    repeat (60) @(negedge clk);
    rd(2, v);
    chk(v == 32'd0, "R2 no go no done", v, 0);
    chk(startCnt == st0 && !sclDriveLow, "R2 bus untouched", startCnt - st0, 0);

    // R9 address-only, R4
    runPacket(1, 0, 0, 0, 1, 7'h5A, 8'h00, 1, 1, 8'h00, 0, 0);
    // R9 no phase flags
    wr(2, 32'hFFFF_FFFF);
    wr(0, mkCmd(0, 0, 0, 0, 0, 7'h01));
    repeat (2) @(negedge clk);
    rd(2, v);
    chk(v == 32'h1_0000, "R9 empty command done", v, 32'h1_0000);
    // R5 transmit ack / nak / address nak
    runPacket(1, 1, 0, 0, 1, 7'h33, 8'hA5, 1, 1, 8'h00, 0, 0);
    runPacket(1, 1, 0, 0, 1, 7'h4C, 8'h3C, 1, 0, 8'h00, 0, 0);
    runPacket(1, 1, 0, 0, 1, 7'h11, 8'hFF, 0, 1, 8'h00, 0, 0);
    // R6 receive final
    runPacket(1, 0, 1, 1, 1, 7'h6B, 8'h00, 1, 1, 8'hC3, 0, 0);
    // R8 hold then R3 repeated open
    runPacket(1, 1, 0, 0, 0, 7'h2D, 8'h81, 1, 1, 8'h00, 0, 0);
    runPacket(1, 0, 1, 1, 1, 7'h2D, 8'h00, 1, 1, 8'h5E, 0, 0);
    // R8 receive stream across two commands
    runPacket(1, 0, 1, 0, 0, 7'h70, 8'h00, 1, 1, 8'h96, 0, 0);
    runPacket(0, 0, 1, 1, 1, 7'h70, 8'h00, 1, 1, 8'h96, 1, 0);
    // R12 command during a packet ignored
    runPacket(1, 1, 0, 0, 1, 7'h15, 8'h42, 1, 1, 8'h00, 0, 1);

    // R11 / R10
    wr(3, 32'h1_0000);
    runPacket(1, 1, 0, 0, 1, 7'h09, 8'h18, 1, 1, 8'h00, 0, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R11 irq enabled done", irq, 1);
    wr(2, 32'h0000_0001);
    rd(2, v);
    chk(v == 32'h1_0000, "R10 clear ack only", v, 32'h1_0000);
    chk(irq == 1'b1, "R11 irq still up", irq, 1);
    wr(3, 32'h0000_0001);
    @(negedge clk);
    chk(irq == 1'b0, "R11 irq masked", irq, 0);
    wr(3, 32'h1_0000);
    wr(2, 32'h1_0000);
    rd(2, v);
    chk(v == 32'd0 && irq == 1'b0, "R10 clear done", v, 0);
    wr(3, 32'd0);

    // random packets
    for (int k = 0; k < 40; k++) begin
      int kind;
      bit p, aA, dA;
      logic [6:0] a;
      logic [7:0] d, rb;
      kind = $urandom % 3;
      p  = 1'($urandom % 2);
      a  = 7'($urandom);
      d  = 8'($urandom);
      rb = 8'($urandom);
      aA = ($urandom % 4) != 0;
      dA = ($urandom % 4) != 0;
      runPacket(1, kind == 1, kind == 2, kind == 2, p, a, d, aA, dA, rb, 0, 0);
    end
    runPacket(1, 0, 0, 0, 1, 7'h00, 8'h00, 1, 1, 8'h00, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule